// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a synchronous host use an external asynchronous 32K x 8 static RAM. The host presents a request with a 15-bit word address, a write flag and 8 bits of write data, then holds the request until a single-cycle acknowledge returns. For a read, the byte fetched from the memory is shown on the read-data port in the acknowledge cycle and stays there until the next read completes.

On the memory side the controller drives active-low chip select, output enable and write enable, the address, and a split data bus (outgoing byte, incoming byte and a drive enable) for an external tri-state pad. Every memory-side output comes from a flop. The length of each phase is a parameter counted in clock ticks. The defaults assume a 100 MHz clock and the faster supply grade of the memory: 85 ns access and cycle, a 65 ns write strobe, 35 ns data setup, and up to 30 ns of output float time. Writes are strobed by write enable while output enable stays high, so the memory never drives the bus during a write. After every read a gap of idle cycles lets the memory's output drivers release the bus before the controller may drive it.

Top module: `sramc_ctrl`

## Requirements
- R1: While reset is applied, and on leaving it, chip select, output enable and write enable are high (inactive), the data drive enable is 0 and the acknowledge is 0.
- R2: A read holds chip select and output enable low, with write enable high, for exactly RD_CYC consecutive cycles (9 by default).
- R3: The read byte is sampled from the memory at the end of the last read-access cycle. It appears on the read-data port together with the acknowledge in the next cycle (cycle RD_CYC+1 after acceptance). The acknowledge lasts one cycle, and the read data does not change until another read samples.
- R4: A write holds chip select low for WE_PULSE+2 cycles: one setup cycle, WE_PULSE cycles with write enable low, and one release cycle with write enable high. Output enable stays high for the whole write.
- R5: The data drive enable rises DATA_SETUP cycles before write enable rises and stays on for one more cycle after it. It is never on while output enable is low.
- R6: After a read, chip select stays high for TURN+1 cycles after the acknowledge cycle before the next access can start. After a write, the next access can start one cycle after the acknowledge.
- R7: A write is acknowledged with a one-cycle pulse in its release cycle, which is cycle WE_PULSE+2 after acceptance.
- R8: Address and write data are captured when a request is accepted and stay stable on the memory side while chip select is low, whatever the host does to its own inputs.
- R9: With no request pending, chip select stays high and the data drive enable stays off. A request held high during a running access does not start a second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Access request, held until acknowledged |
| host_wr | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write byte |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Last byte read |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Byte to drive onto the memory data bus |
| mem_dq_oe | output | 1 | Drive enable for the data pad |
| mem_dq_in | input | DATA_W | Byte seen on the memory data bus |

## Verification
The assertions assume a host that lowers its request in the same cycle it sees the acknowledge, or issues the next request immediately. They also assume reset is applied from time zero. The stimulus keeps to this: it raises a request at a falling clock edge, keeps it high through the whole access while it scrambles the address, data and write flag, and drops or renews it at the acknowledge. A small memory model in the bench returns valid data only after output enable has been low for the full access time. It stores a marker byte if write enable rises while the data pad is not driven, so any early sampling or drive-timing error shows up as wrong read-back data in the address sweeps.

// File: rtl/sramc_pkg.sv
package sramc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ACCESS,
      ST_RD_DONE,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_RELEASE,
      ST_TURNAROUND
   } sramc_state_e;
endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] cnt_d,
   output logic          zero
);
   always_comb begin
      if (load)
         cnt_d = load_val;
      else if (cnt_q != '0)
         cnt_d = cnt_q - 1'b1;
      else
         cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign zero = (cnt_q == '0);

   // R2: an unloaded, nonzero count steps down by exactly one
   p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/sramc_hold.sv
module sramc_hold #(
   parameter int AW = 15,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          sample,
   input  logic [DW-1:0] rd_i,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] wdata_q,
   output logic [DW-1:0] rdata_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (capture) begin
         addr_q  <= addr_i;
         wdata_q <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (sample) rdata_q <= rd_i;
   end

   // R3: read data only moves on a sampling edge
   p_rdata_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sample) |-> $stable(rdata_q));
   // R8: captured request fields only move on an accepting edge
   p_fields_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(capture) |-> ($stable(addr_q) && $stable(wdata_q)));
endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
   import sramc_pkg::*;
#(
   parameter int ADDR_W     = 15,
   parameter int DATA_W     = 8,
   parameter int RD_CYC     = 9,
   parameter int WE_PULSE   = 7,
   parameter int DATA_SETUP = 4,
   parameter int TURN       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_ack,
   output logic [DATA_W-1:0] host_rdata,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int MAX_A = (RD_CYC > WE_PULSE) ? RD_CYC : WE_PULSE;
   localparam int MAXC  = (MAX_A > TURN) ? MAX_A : TURN;
   localparam int CW    = $clog2(MAXC + 1);
   localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
   localparam logic [CW-1:0] WE_LOAD = CW'(WE_PULSE - 1);
   localparam logic [CW-1:0] DS_C    = CW'(DATA_SETUP);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sramc_ctrl: bus widths must be positive");
   end
   if (RD_CYC < 1 || WE_PULSE < 1) begin : g_bad_strobe
      $error("sramc_ctrl: read and strobe lengths must be at least one cycle");
   end
   if (DATA_SETUP < 1 || DATA_SETUP > WE_PULSE) begin : g_bad_setup
      $error("sramc_ctrl: data setup must lie within the strobe");
   end
   if (TURN < 0) begin : g_bad_turn
      $error("sramc_ctrl: turnaround cannot be negative");
   end

   sramc_state_e    st_q, st_d, rd_exit;
   logic            load, zero;
   logic [CW-1:0]   load_val, cnt_q, cnt_d, turn_val;
   logic            accept, sample;

   if (TURN > 0) begin : g_turn
      assign rd_exit  = ST_TURNAROUND;
      assign turn_val = CW'(TURN - 1);
   end else begin : g_no_turn
      assign rd_exit  = ST_IDLE;
      assign turn_val = '0;
   end

   assign accept = (st_q == ST_IDLE) && host_req;
   assign sample = (st_q == ST_RD_ACCESS) && zero;

   always_comb begin
      st_d     = st_q;
      load     = 1'b0;
      load_val = '0;
      unique case (st_q)
         ST_IDLE: if (host_req) begin
            load = 1'b1;
            if (host_wr) st_d = ST_WR_SETUP;
            else begin
               st_d     = ST_RD_ACCESS;
               load_val = RD_LOAD;
            end
         end
         ST_RD_ACCESS: if (zero) st_d = ST_RD_DONE;
         ST_RD_DONE: begin
            st_d     = rd_exit;
            load     = 1'b1;
            load_val = turn_val;
         end
         ST_TURNAROUND: if (zero) st_d = ST_IDLE;
         ST_WR_SETUP: begin
            st_d     = ST_WR_PULSE;
            load     = 1'b1;
            load_val = WE_LOAD;
         end
         ST_WR_PULSE:   if (zero) st_d = ST_WR_RELEASE;
         ST_WR_RELEASE: st_d = ST_IDLE;
         default:       st_d = ST_IDLE;
      endcase
   end

   sramc_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .cnt_q    (cnt_q),
      .cnt_d    (cnt_d),
      .zero     (zero)
   );

   sramc_hold #(.AW(ADDR_W), .DW(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (accept),
      .addr_i  (host_addr),
      .wdata_i (host_wdata),
      .sample  (sample),
      .rd_i    (mem_dq_in),
      .addr_q  (mem_addr),
      .wdata_q (mem_dq_out),
      .rdata_q (host_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         mem_cs_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
         host_ack  <= 1'b0;
      end else begin
         st_q      <= st_d;
         mem_cs_n  <= (st_d == ST_IDLE) || (st_d == ST_RD_DONE) ||
                      (st_d == ST_TURNAROUND);
         mem_oe_n  <= (st_d != ST_RD_ACCESS);
         mem_we_n  <= (st_d != ST_WR_PULSE);
         mem_dq_oe <= ((st_d == ST_WR_PULSE) && (cnt_d < DS_C)) ||
                      (st_d == ST_WR_RELEASE);
         host_ack  <= (st_d == ST_RD_DONE) || (st_d == ST_WR_RELEASE);
      end
   end

   // R2: output enable only during a selected, non-writing cycle
   p_oe_in_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_cs_n && mem_we_n));
   // R4: write strobe only inside chip select, with output enable high
   p_we_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs_n && mem_oe_n));
   // R5: the pad never drives while the memory may drive
   p_no_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);
   // R5: write enable rises with data still driven
   p_data_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && $past(mem_dq_oe)));
   // R3: acknowledge is a single-cycle pulse
   p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |=> !host_ack);
   // R8: address held while the memory is selected
   p_addr_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
   // R9: deselected memory sees no strobes and no drive
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));
endmodule

// File: tb/test_sramc_ctrl.sv
module test_sramc_ctrl;
   localparam int RD_CYC = 9, WE_PULSE = 7, DATA_SETUP = 4, TURN = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_wr = 1'b0;
   logic [14:0] host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic        host_ack;
   logic [7:0]  host_rdata;
   logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [14:0] mem_addr;
   logic [7:0]  mem_dq_out, mem_dq_in;

   always #5 clk = ~clk;

   sramc_ctrl i_sramc_ctrl (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
      .host_rdata(host_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // memory model: folded to 256 bytes, data valid only after full access time
   logic [7:0] model [256];
   int rd_age = 0;
   logic rd_en;
   assign rd_en = !mem_cs_n && !mem_oe_n && mem_we_n;
   always @(posedge clk) rd_age <= rd_en ? rd_age + 1 : 0;
   assign mem_dq_in = (rd_en && rd_age >= RD_CYC - 1) ? model[mem_addr[7:0]] : 8'hC3;
   always @(posedge mem_we_n)
      if (rst_n && !mem_cs_n) model[mem_addr[7:0]] <= mem_dq_oe ? mem_dq_out : 8'hEE;

   int total = 0, bad = 0;
   bit finished = 1'b0;
   bit prev_rd = 1'b0, have_prev = 1'b0;
   logic [7:0] last_rd = 8'h00;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int i, input int pass);
      return 8'((i * 37) + (pass * 91) + 5);
   endfunction

   function automatic logic [14:0] adr(input int i, input int pass);
      return {7'((i * 13) + pass * 5), 8'(i)};
   endfunction

   task automatic xact(input bit wr, input logic [14:0] a, input logic [7:0] d,
                       input logic [7:0] exp_rd);
      int waits = 0, c = 0, cs_lo = 0, oe_lo = 0, we_lo = 0, dq_n = 0;
      int first_dq = 0, addr_bad = 0, data_bad = 0, clash = 0, early_ack = 0;
      host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
      do begin
         @(negedge clk);
         waits++;
         if (host_ack && mem_cs_n) early_ack++;
      end while (mem_cs_n && waits < 100);
      chk(early_ack == 0, "R3 ack longer than one cycle", early_ack, 0);
      if (have_prev)
         chk(waits - 1 == (prev_rd ? TURN + 1 : 1), "R6 gap before next access",
             waits - 1, prev_rd ? TURN + 1 : 1);
      // scramble host inputs while the access runs (R8, R9)
      host_addr = ~a; host_wdata = ~d; host_wr = ~wr;
      forever begin
         c++;
         if (!mem_cs_n) cs_lo++;
         if (!mem_oe_n) oe_lo++;
         if (!mem_we_n) we_lo++;
         if (mem_dq_oe) begin
            dq_n++;
            if (first_dq == 0) first_dq = c;
            if (mem_dq_out != d) data_bad++;
            if (!mem_oe_n) clash++;
         end
         if (!mem_cs_n && mem_addr != a) addr_bad++;
         if (host_ack || c >= 50) break;
         @(negedge clk);
      end
      chk(addr_bad == 0, "R8 address held", addr_bad, 0);
      if (!wr) begin
         chk(c == RD_CYC + 1, "R3 read ack cycle", c, RD_CYC + 1);
         chk(oe_lo == RD_CYC, "R2 output enable cycles", oe_lo, RD_CYC);
         chk(cs_lo == RD_CYC, "R2 chip select cycles", cs_lo, RD_CYC);
         chk(we_lo == 0, "R2 write enable high", we_lo, 0);
         chk(dq_n == 0, "R5 no drive in read", dq_n, 0);
         chk(host_rdata == exp_rd, "R3 read data", host_rdata, exp_rd);
         last_rd = host_rdata;
      end else begin
         chk(c == WE_PULSE + 2, "R7 write ack cycle", c, WE_PULSE + 2);
         chk(cs_lo == WE_PULSE + 2, "R4 chip select cycles", cs_lo, WE_PULSE + 2);
         chk(we_lo == WE_PULSE, "R4 strobe cycles", we_lo, WE_PULSE);
         chk(oe_lo == 0, "R4 output enable high", oe_lo, 0);
         chk(dq_n == DATA_SETUP + 1, "R5 drive length", dq_n, DATA_SETUP + 1);
         chk(first_dq == WE_PULSE - DATA_SETUP + 2, "R5 drive start", first_dq,
             WE_PULSE - DATA_SETUP + 2);
         chk(data_bad == 0, "R8 write data held", data_bad, 0);
         chk(clash == 0, "R5 drive against memory", clash, 0);
         chk(host_rdata == last_rd, "R3 read data kept over write", host_rdata, last_rd);
      end
      host_req = 1'b0;
      prev_rd = !wr; have_prev = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes inactive in reset",
          {mem_cs_n, mem_oe_n, mem_we_n}, 7);
      chk(!mem_dq_oe && !host_ack, "R1 drive and ack off", {mem_dq_oe, host_ack}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_cs_n && !mem_dq_oe && !host_ack, "R1 state after reset",
          {mem_cs_n, mem_dq_oe, host_ack}, 4);
      // pass 0: write every low-byte address, then read back downwards
      for (int i = 0; i < 256; i++) xact(1'b1, adr(i, 0), pat(i, 0), 8'h00);
      for (int i = 255; i >= 0; i--) xact(1'b0, adr(i, 1), 8'h00, pat(i, 0));
      // pass 1: write then immediately read the same word
      for (int i = 0; i < 256; i += 3) begin
         xact(1'b1, adr(i, 2), pat(i, 1), 8'h00);
         xact(1'b0, adr(i, 2), 8'h00, pat(i, 1));
      end
      // R9: idle with no request
      begin
         int busy = 0;
         repeat (20) begin
            @(negedge clk);
            if (!mem_cs_n || mem_dq_oe || host_ack) busy++;
         end
         chk(busy == 0, "R9 idle stays deselected", busy, 0);
      end
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         chk(1'b0, "watchdog expired", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule